// File: doc/BRIEF.md
# Rail Power-Good Supervisor with Reset Timer

This block decides when a group of voltage rails may be reported as good. Each rail reaches it as two comparator flags: one that is set while the rail sits above its upper (rising) threshold, and one that is set while the rail sits below its lower (falling) threshold. Each flag must hold steadily for a deglitch interval before the rail's qualified state changes. Between the two thresholds the qualified state does not change.

Power-good is released only after three conditions hold. Every rail must have qualified at least once since the rails were enabled, which marks the startup sequence as complete. Every rail must be qualified now. A minimum reset period must have run out. That period is counted from the later of two reference rails reaching qualification. If any rail that had qualified loses qualification, the period starts again from zero. A startup watchdog flags each rail that has not crossed its upper threshold within a set time after enable. Every interval is a count of a single-cycle millisecond tick, so simulation can use small values. Dropping the enable clears every timer and drives the output inactive. A parameter selects the output polarity.

Top module: `rail_pg_supervisor`

## Requirements
- R1: After reset, and one cycle after `rails_en` is sampled low, `pgood` is at its inactive level and `start_fail` is all zeros. All internal timers restart from zero.
- R2: A rail becomes qualified on the DGL_MS-th tick through which its `above_rise` bit (1 = above the rising threshold) has stayed at 1 without a break. A break before that tick restarts the count.
- R3: A qualified rail loses qualification on the DGL_MS-th tick through which its `below_fall` bit (1 = below the falling threshold) has stayed at 1 without a break. A shorter low excursion leaves `pgood` unchanged.
- R4: While both flags of a rail are 0, the rail keeps its qualified state, whether that state is qualified or not.
- R5: `pgood` goes active only when every rail is qualified and every rail has qualified at least once since enable. A rail that has not yet qualified holds `pgood` inactive, even after the reset period has run out.
- R6: The reset period counts RST_MS ticks. It starts after the later of rails REF_A and REF_B (defaults 0 and 2) has become qualified, and `pgood` goes active the cycle after the period ends.
- R7: If any rail that had qualified loses qualification, the reset period clears. Once the rail qualifies again, `pgood` returns only after a further full RST_MS ticks.
- R8: `start_fail[i]` is set on the WDOG_MS-th tick after enable if `above_rise[i]` has not been 1 at any point since enable. It stays set until `rails_en` drops.
- R9: With ACTIVE_HIGH = 1 (the default), `pgood` is 1 when active. With ACTIVE_HIGH = 0 the level is inverted.
- R10: No qualification, timer or watchdog state advances in a cycle where `ms_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | Single-cycle millisecond timebase pulse |
| rails_en | input | 1 | Rails enabled. Low clears all state |
| above_rise | input | N_RAILS | Per rail: 1 = above the rising threshold |
| below_fall | input | N_RAILS | Per rail: 1 = below the falling threshold |
| pgood | output | 1 | Power-good, polarity set by ACTIVE_HIGH |
| start_fail | output | N_RAILS | Per rail: sticky flag for a rail that did not reach regulation in time |

## Verification
The assertions assume that `ms_tick` is a pulse one cycle wide with idle cycles between pulses. They also assume that a rail's two flags are never set together, because a rail cannot be above the upper threshold and below the lower one at once. The bench drives each rail only through three legal levels (low, between thresholds, good), so the flag pair is always one of three legal combinations. It issues ticks three cycles apart, which gives every registered result a full idle cycle to settle before the outputs are sampled.

// File: rtl/rail_pg_pkg.sv
package rail_pg_pkg;

  // Counter width able to hold the value lim.
  function automatic int cnt_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // True when an event lands on the final step of a lim-step count.
  function automatic logic last_step(input logic ev, input int unsigned cnt,
                                     input int unsigned lim);
    return ev && ((cnt + 1) >= lim);
  endfunction

endpackage

// File: rtl/pg_rail_qual.sv
module pg_rail_qual
  import rail_pg_pkg::*;
#(
  parameter int unsigned DGL_MS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ms_tick,
  input  logic above_ok,
  input  logic below_bad,
  output logic qualified,
  output logic ever_up
);
  localparam int W = cnt_w(DGL_MS);

  logic [W-1:0] cnt;
  logic         watch;
  logic         flip;

  // The flag that could move the current state.
  assign watch = qualified ? below_bad : above_ok;
  assign flip  = last_step(ms_tick && watch, 32'(cnt), DGL_MS);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt       <= '0;
      qualified <= 1'b0;
      ever_up   <= 1'b0;
    end else begin
      if (!watch) begin
        cnt <= '0;
      end else if (flip) begin
        cnt       <= '0;
        qualified <= ~qualified;
        if (!qualified) ever_up <= 1'b1;
      end else if (ms_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pg_start_watchdog.sv
module pg_start_watchdog
  import rail_pg_pkg::*;
#(
  parameter int unsigned N_RAILS = 3,
  parameter int unsigned WDOG_MS = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               ms_tick,
  input  logic [N_RAILS-1:0] above_ok,
  output logic [N_RAILS-1:0] fail,
  output logic               expire
);
  localparam int W = cnt_w(WDOG_MS);

  logic [W-1:0]       cnt;
  logic [N_RAILS-1:0] seen;
  logic               done;

  assign expire = !done && last_step(ms_tick, 32'(cnt), WDOG_MS);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt  <= '0;
      seen <= '0;
      done <= 1'b0;
      fail <= '0;
    end else begin
      seen <= seen | above_ok;
      if (expire) begin
        done <= 1'b1;
        fail <= ~(seen | above_ok);
      end else if (!done && ms_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pg_reset_timer.sv
module pg_reset_timer
  import rail_pg_pkg::*;
#(
  parameter int unsigned RST_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ms_tick,
  input  logic run,
  output logic done
);
  localparam int W = cnt_w(RST_MS);

  logic [W-1:0] cnt;

  assign done = (32'(cnt) == RST_MS);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || !run) begin
      cnt <= '0;
    end else if (ms_tick && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rail_pg_supervisor.sv
module rail_pg_supervisor
  import rail_pg_pkg::*;
#(
  parameter int unsigned N_RAILS     = 3,
  parameter int unsigned DGL_MS      = 11,
  parameter int unsigned RST_MS      = 100,
  parameter int unsigned WDOG_MS     = 11,
  parameter int unsigned REF_A       = 0,
  parameter int unsigned REF_B       = 2,
  parameter bit          ACTIVE_HIGH = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ms_tick,
  input  logic               rails_en,
  input  logic [N_RAILS-1:0] above_rise,
  input  logic [N_RAILS-1:0] below_fall,
  output logic               pgood,
  output logic [N_RAILS-1:0] start_fail
);
  // Named internal events, brought out for the checker.
  logic [N_RAILS-1:0] rail_ok;
  logic [N_RAILS-1:0] rail_seen;
  logic               all_ok;
  logic               seq_done;
  logic               fault;
  logic               tmr_run;
  logic               tmr_done;
  logic               wd_expired;
  logic               pg_int;
  logic               pg_q;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_qual
    pg_rail_qual #(.DGL_MS(DGL_MS)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (rails_en),
      .ms_tick   (ms_tick),
      .above_ok  (above_rise[i]),
      .below_bad (below_fall[i]),
      .qualified (rail_ok[i]),
      .ever_up   (rail_seen[i])
    );
  end

  assign all_ok   = &rail_ok;
  assign seq_done = &rail_seen;
  assign fault    = |(rail_seen & ~rail_ok);
  assign tmr_run  = rail_ok[REF_A] && rail_ok[REF_B] && !fault;

  pg_reset_timer #(.RST_MS(RST_MS)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (rails_en),
    .ms_tick (ms_tick),
    .run     (tmr_run),
    .done    (tmr_done)
  );

  pg_start_watchdog #(.N_RAILS(N_RAILS), .WDOG_MS(WDOG_MS)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (rails_en),
    .ms_tick  (ms_tick),
    .above_ok (above_rise),
    .fail     (start_fail),
    .expire   (wd_expired)
  );

  assign pg_int = all_ok && seq_done && tmr_done;

  always_ff @(posedge clk) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= rails_en && pg_int;
  end

  if (ACTIVE_HIGH) begin : g_pol_hi
    assign pgood = pg_q;
  end else begin : g_pol_lo
    assign pgood = ~pg_q;
  end
endmodule

// File: rtl/rail_pg_supervisor_chk.sv
module rail_pg_supervisor_chk #(
  parameter int unsigned N_RAILS = 3,
  parameter int unsigned REF_A   = 0,
  parameter int unsigned REF_B   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ms_tick,
  input logic               rails_en,
  input logic [N_RAILS-1:0] above_rise,
  input logic [N_RAILS-1:0] below_fall,
  input logic [N_RAILS-1:0] rail_ok,
  input logic               tmr_done,
  input logic               wd_expired,
  input logic               pg_q,
  input logic [N_RAILS-1:0] start_fail
);
  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    // R2
    ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_ok[i]) |-> $past(ms_tick && above_rise[i] && rails_en));
    // R3
    ok_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_ok[i]) |-> $past(!rails_en || (ms_tick && below_fall[i])));
  end

  // R1
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rails_en |=> (!pg_q && start_fail == '0));

  // R5
  pg_all_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_q |-> $past(&rail_ok));

  // R6
  tmr_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_done) |-> $past(ms_tick && rail_ok[REF_A] && rail_ok[REF_B]));

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rails_en && $past(rails_en)) |-> ((start_fail & $past(start_fail)) == $past(start_fail)));

  // R8
  fail_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_expired) |-> ms_tick);

  // R10
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rails_en && !ms_tick) |=> ($stable(rail_ok) && $stable(start_fail)));
endmodule

bind rail_pg_supervisor rail_pg_supervisor_chk #(
  .N_RAILS (N_RAILS),
  .REF_A   (REF_A),
  .REF_B   (REF_B)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ms_tick    (ms_tick),
  .rails_en   (rails_en),
  .above_rise (above_rise),
  .below_fall (below_fall),
  .rail_ok    (rail_ok),
  .tmr_done   (tmr_done),
  .wd_expired (wd_expired),
  .pg_q       (pg_q),
  .start_fail (start_fail)
);

// File: tb/rail_pg_supervisor_test.sv
module rail_pg_supervisor_test;
  localparam int DGL  = 3;
  localparam int RST  = 6;
  localparam int WDOG = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       rails_en = 1'b0;
  logic [2:0] above = '0;
  logic [2:0] below = '1;
  logic       pgood, pgood_inv;
  logic [2:0] start_fail, start_fail_inv;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  rail_pg_supervisor #(.N_RAILS(3), .DGL_MS(DGL), .RST_MS(RST), .WDOG_MS(WDOG))
  uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rails_en(rails_en),
    .above_rise(above), .below_fall(below), .pgood(pgood), .start_fail(start_fail)
  );

  rail_pg_supervisor #(.N_RAILS(3), .DGL_MS(DGL), .RST_MS(RST), .WDOG_MS(WDOG),
                       .ACTIVE_HIGH(1'b0))
  uut_inv (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rails_en(rails_en),
    .above_rise(above), .below_fall(below), .pgood(pgood_inv),
    .start_fail(start_fail_inv)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Level 0 = below falling threshold, 1 = between thresholds, 2 = good.
  task automatic set_rail(input int i, input int lvl);
    above[i] = (lvl == 2);
    below[i] = (lvl == 0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic shut_off();
    @(negedge clk) rails_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start(input int l0, input int l1, input int l2);
    shut_off();
    set_rail(0, l0); set_rail(1, l1); set_rail(2, l2);
    rails_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 pgood after reset", pgood, 0);
    chk("R1 start_fail after reset", start_fail, 0);
    chk("R9 inverted pgood after reset", pgood_inv, 1);
  endtask

  task automatic t_normal();
    start(2, 2, 2);
    ticks(8);
    chk("R6 pgood one tick before period end", pgood, 0);
    ticks(1);
    chk("R6 pgood at period end", pgood, 1);
    chk("R9 inverted pgood active", pgood_inv, 0);
    chk("R8 no start failure", start_fail, 0);
    @(negedge clk) rails_en = 1'b0;
    @(negedge clk);
    chk("R1 pgood one cycle after disable", pgood, 0);
    chk("R9 inverted pgood after disable", pgood_inv, 1);
  endtask

  task automatic t_rise_break();
    start(2, 2, 2);
    ticks(2);
    set_rail(2, 1);
    ticks(1);
    set_rail(2, 2);
    ticks(8);
    chk("R2 broken rise restarts qualification", pgood, 0);
    ticks(1);
    chk("R2 R6 pgood from later ref rail", pgood, 1);
    chk("R8 rail seen above, no failure", start_fail, 0);
  endtask

  task automatic t_glitch();
    start(2, 2, 2);
    ticks(9);
    chk("R6 pgood before glitch tests", pgood, 1);
    set_rail(1, 0);
    ticks(2);
    set_rail(1, 2);
    ticks(1);
    chk("R3 short low excursion ignored", pgood, 1);
    set_rail(1, 1);
    ticks(10);
    chk("R4 between thresholds keeps qualified", pgood, 1);
    set_rail(1, 0);
    ticks(2);
    chk("R3 two low ticks still good", pgood, 1);
    ticks(1);
    chk("R3 deglitched drop", pgood, 0);
    set_rail(1, 1);
    ticks(5);
    chk("R4 between thresholds keeps unqualified", pgood, 0);
    set_rail(1, 2);
    ticks(8);
    chk("R7 reset period restarted", pgood, 0);
    ticks(1);
    chk("R7 pgood after full period", pgood, 1);
  endtask

  task automatic t_nonref();
    start(2, 1, 2);
    ticks(4);
    chk("R8 watchdog not yet expired", start_fail, 0);
    ticks(1);
    chk("R8 watchdog flags rail 1", start_fail, 3'b010);
    ticks(7);
    chk("R5 missing rail holds pgood", pgood, 0);
    set_rail(1, 2);
    ticks(2);
    chk("R5 rail not yet qualified", pgood, 0);
    ticks(1);
    chk("R5 pgood once last rail qualifies", pgood, 1);
    chk("R8 failure flag sticky", start_fail, 3'b010);
    shut_off();
    chk("R1 failure flag cleared by disable", start_fail, 0);
  endtask

  task automatic t_watchdog();
    start(2, 2, 0);
    ticks(4);
    chk("R8 rail 2 before expiry", start_fail, 0);
    ticks(1);
    chk("R8 rail 2 flagged", start_fail, 3'b100);
    chk("R5 pgood inactive with low rail", pgood, 0);
  endtask

  task automatic t_no_tick();
    start(2, 2, 2);
    repeat (200) @(negedge clk);
    chk("R10 pgood without ticks", pgood, 0);
    chk("R10 start_fail without ticks", start_fail, 0);
    ticks(9);
    chk("R10 R6 pgood after ticks resume", pgood, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_rise_break();
    t_glitch();
    t_nonref();
    t_watchdog();
    t_no_tick();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule